// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray-Coded Pointers

This block moves data words from a producer running on one clock to a consumer running on a second clock that has no phase or frequency relationship with the first. Words are stored in a small register array. The write side owns the write pointer and the full flag. The read side owns the read pointer and the empty flag. Each pointer is held both in binary form and in reflected Gray form. Only the Gray form leaves its domain, through a two-flop synchronizer clocked by the receiving side. The flags are computed only from the local pointer and the synchronized copy of the remote one.

The read port works in look-ahead style. While `rd_empty` is low, `rd_data` already shows the oldest stored word, and raising `rd_en` for one read clock removes that word. A write is accepted on a write clock edge where `wr_en` is high and `wr_full` is low.

Each side sees the other pointer only after a delay, so the flags are pessimistic. Empty can linger for a few read clocks after a write, and full can linger for a few write clocks after a read. Neither flag ever reports data or space that is not there.

Top module: `dcfifo_gray`

## Requirements
- R1: Once each reset has been applied, `rd_empty` reads 1 and `wr_full` reads 0.
- R2: Words leave in the order they were accepted. While `rd_empty` is 0, `rd_data` presents the oldest word. A read clock edge with `rd_en`=1 and `rd_empty`=0 removes that word, and empty rises on that same edge when the last word leaves.
- R3: Capacity is 2^ADDR_W words. With no reads, `wr_full` stays 0 after 2^ADDR_W-1 accepted writes and reads 1 from the write clock edge that accepts write number 2^ADDR_W.
- R4: A write attempted while `wr_full` is 1 is dropped. The write pointer stays put, and the dropped word never appears at `rd_data`.
- R5: A read attempted while `rd_empty` is 1 is dropped. The read pointer stays put, and the next word written is the next word read.
- R6: After a write into an empty FIFO, `rd_empty` is still 1 at the first read clock falling edge that follows the accepting write edge. It falls within 8 read clocks.
- R7: After a read from a full FIFO, `wr_full` is still 1 at the first write clock falling edge that follows the read edge. It falls within 8 write clocks.
- R8: Each pointer crosses domains only as a Gray code, and any one clock edge changes at most one of its bits.
- R9: Long streams that wrap the pointers many times deliver every word intact, under several ratios of producer and consumer duty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No room: writes are dropped |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain asynchronous reset, active low |
| rd_en | input | 1 | Remove the word shown on rd_data |
| rd_data | output | DATA_W | Oldest stored word |
| rd_empty | output | 1 | No data: reads are dropped |

## Verification
The bench builds the block with DATA_W=8 and ADDR_W=2. A four-word store is filled and drained in a handful of accesses, so the exact full threshold, the dropped write into a full store and the dropped read from an empty store can all be checked directly. With a three-bit pointer, the 24-word streams wrap each pointer several times in every pattern. The write clock runs at 20 ns and the read clock at 34 ns, and the streams are run under four producer and consumer gap patterns. This covers many phase relationships between the clocks, as well as both the full-bound and the empty-bound regimes.

// File: rtl/dcfifo_gray_pkg.sv
`timescale 1ns/1ps
package dcfifo_gray_pkg;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/dcfifo_sync.sv
`timescale 1ns/1ps
module dcfifo_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = dcfifo_gray_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dcfifo_wside.sv
`timescale 1ns/1ps
module dcfifo_wside #(
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned PW    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [PW-1:0]     peer_gray,
  output logic [ADDR_W-1:0] addr,
  output logic [PW-1:0]     gray,
  output logic              push,
  output logic              full
);
  localparam logic [PW-1:0] TOP2 = PW'(3) << (PW-2);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic full_match(input logic [PW-1:0] own, input logic [PW-1:0] peer);
    return own == (peer ^ TOP2);
  endfunction

  logic [PW-1:0] bin, bin_nx, gray_nx;

  assign push    = req & ~full;
  assign bin_nx  = bin + PW'(push);
  assign gray_nx = to_gray(bin_nx);
  assign addr    = bin[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin  <= '0;
      gray <= '0;
      full <= 1'b0;
    end else begin
      bin  <= bin_nx;
      gray <= gray_nx;
      full <= full_match(gray_nx, peer_gray);
    end
  end
endmodule

// File: rtl/dcfifo_rside.sv
`timescale 1ns/1ps
module dcfifo_rside #(
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned PW    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [PW-1:0]     peer_gray,
  output logic [ADDR_W-1:0] addr,
  output logic [PW-1:0]     gray,
  output logic              pop,
  output logic              empty
);
  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [PW-1:0] bin, bin_nx, gray_nx;

  assign pop     = req & ~empty;
  assign bin_nx  = bin + PW'(pop);
  assign gray_nx = to_gray(bin_nx);
  assign addr    = bin[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin   <= '0;
      gray  <= '0;
      empty <= 1'b1;
    end else begin
      bin   <= bin_nx;
      gray  <= gray_nx;
      empty <= (gray_nx == peer_gray);
    end
  end
endmodule

// File: rtl/dcfifo_store.sv
`timescale 1ns/1ps
module dcfifo_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcfifo_gray.sv
`timescale 1ns/1ps
module dcfifo_gray #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);
  localparam int unsigned PW = ADDR_W + 1;

  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     wgray, rgray, rgray_in_w, wgray_in_r;
  logic              wr_push, rd_pop;

  dcfifo_wside #(.ADDR_W(ADDR_W)) u_wside (
    .clk(wr_clk), .rst_n(wr_rst_n), .req(wr_en), .peer_gray(rgray_in_w),
    .addr(waddr), .gray(wgray), .push(wr_push), .full(wr_full)
  );

  dcfifo_rside #(.ADDR_W(ADDR_W)) u_rside (
    .clk(rd_clk), .rst_n(rd_rst_n), .req(rd_en), .peer_gray(wgray_in_r),
    .addr(raddr), .gray(rgray), .pop(rd_pop), .empty(rd_empty)
  );

  dcfifo_sync #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_in_w)
  );

  dcfifo_sync #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_in_r)
  );

  dcfifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .wclk(wr_clk), .we(wr_push), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: rtl/dcfifo_gray_chk.sv
`timescale 1ns/1ps
module dcfifo_gray_chk #(
  parameter int unsigned PW = 3
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          wr_en,
  input logic          wr_full,
  input logic          wr_push,
  input logic [PW-1:0] wgray,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          rd_en,
  input logic          rd_empty,
  input logic          rd_pop,
  input logic [PW-1:0] rgray
);
  p_full_drop_r4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_en && wr_full) |=> $stable(wgray));

  p_empty_drop_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && rd_empty) |=> $stable(rgray));

  p_wgray_step_r8: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  p_rgray_step_r8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

  p_push_moves_r2: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_push |=> !$stable(wgray));

  p_pop_moves_r2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_pop |=> !$stable(rgray));
endmodule

bind dcfifo_gray dcfifo_gray_chk #(.PW(ADDR_W + 1)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_full(wr_full),
  .wr_push(wr_push), .wgray(wgray),
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_empty(rd_empty),
  .rd_pop(rd_pop), .rgray(rgray)
);

// File: tb/tb_dcfifo_gray.sv
`timescale 1ns/1ps
module tb_dcfifo_gray;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam int DEPTH = 1 << AW;
  localparam int NSTREAM = 24;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic wr_full, rd_empty;

  int checks = 0;
  int errors = 0;

  always #10 wr_clk = ~wr_clk;
  always #17 rd_clk = ~rd_clk;

  dcfifo_gray #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
    .rd_data(rd_data), .rd_empty(rd_empty)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [DW-1:0] d);
    @(negedge wr_clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge wr_clk) wr_en = 1'b0;
  endtask

  task automatic take();
    @(negedge rd_clk) rd_en = 1'b1;
    @(negedge rd_clk) rd_en = 1'b0;
  endtask

  task automatic wait_not_empty(input string req);
    int n = 0;
    while (rd_empty && n < 8) begin @(negedge rd_clk); n++; end
    chk(req, int'(rd_empty), 0);
  endtask

  task automatic stream(input int wgap, input int rgap, input int base);
    fork
      begin : writer
        int k = 0;
        int slot = 0;
        while (k < NSTREAM) begin
          @(negedge wr_clk);
          if (!wr_full && (slot % (wgap + 1)) == 0) begin
            wr_en = 1'b1; wr_data = DW'(base + k); k++;
          end else wr_en = 1'b0;
          slot++;
        end
        @(negedge wr_clk) wr_en = 1'b0;
      end
      begin : reader
        int k = 0;
        int slot = 0;
        while (k < NSTREAM) begin
          @(negedge rd_clk);
          if (!rd_empty && (slot % (rgap + 1)) == 0) begin
            chk("R9 stream data", int'(rd_data), (base + k) & 8'hFF);
            rd_en = 1'b1; k++;
          end else rd_en = 1'b0;
          slot++;
        end
        @(negedge rd_clk) rd_en = 1'b0;
      end
    join
    repeat (8) @(negedge rd_clk);
    chk("R9 drained", int'(rd_empty), 1);
  endtask

  initial begin : watchdog
    #3000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge wr_clk);
    wr_rst_n = 1'b1;
    @(negedge rd_clk) rd_rst_n = 1'b1;
    repeat (3) @(negedge rd_clk);

    // R1: reset state
    chk("R1 empty after reset", int'(rd_empty), 1);
    chk("R1 full after reset", int'(wr_full), 0);

    // R5: reads while empty are dropped
    @(negedge rd_clk) rd_en = 1'b1;
    repeat (3) @(negedge rd_clk);
    rd_en = 1'b0;
    chk("R5 still empty", int'(rd_empty), 1);
    put(8'h5A);
    @(negedge rd_clk);
    chk("R6 empty lingers after write", int'(rd_empty), 1);
    wait_not_empty("R6 empty falls");
    chk("R5 next written word is next read", int'(rd_data), 8'h5A);
    take();
    chk("R2 empty on last pop", int'(rd_empty), 1);

    // R3: exact capacity with no reads
    repeat (10) @(negedge wr_clk);
    for (int i = 0; i < DEPTH; i++) begin
      put(DW'(8'h10 + i));
      if (i == DEPTH - 2) chk("R3 not full one short", int'(wr_full), 0);
    end
    chk("R3 full at capacity", int'(wr_full), 1);

    // R4: write while full is dropped
    put(8'hEE);
    chk("R4 full held", int'(wr_full), 1);

    // R7: full lingers after a read, then falls
    wait_not_empty("R2 data visible");
    chk("R2 oldest first", int'(rd_data), 8'h10);
    take();
    @(negedge wr_clk);
    chk("R7 full lingers after read", int'(wr_full), 1);
    begin
      int n = 0;
      while (wr_full && n < 8) begin @(negedge wr_clk); n++; end
      chk("R7 full falls", int'(wr_full), 0);
    end
    for (int i = 1; i < DEPTH; i++) begin
      @(negedge rd_clk);
      chk("R4 R2 drain order, dropped word absent", int'(rd_data), 8'h10 + i);
      take();
    end
    chk("R2 empty after drain", int'(rd_empty), 1);
    repeat (10) @(negedge wr_clk);

    // R9: streams under several duty patterns
    stream(0, 0, 8'h20);
    stream(0, 3, 8'h60);
    stream(3, 0, 8'hA0);
    stream(1, 2, 8'hF0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule